// File: doc/BRIEF.md
# Return-Address Hash Store/Check Unit

This unit executes two fixed-point instructions that protect saved return addresses. Both compute a 64-bit keyed digest of two operand doublewords, A and B. The store form writes that digest to memory. The check form reads a doubleword from memory and raises a program trap when it differs from the digest. The unit decodes the instruction word and forms the effective address. It detects the invalid form and holds the key in a special register that only privileged code may access.

Instructions arrive on a valid/ready port. `in_ready` is high only while the unit is idle. An instruction is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low until after the completion pulse, so a producer holding `in_valid` simply waits.

Memory uses a plain request/acknowledge port. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until a cycle with `mem_ack` high. For loads, `mem_rdata` is taken in that same cycle.

The digest is built in three steps:
- **Byte interleave.** The operands are interleaved bytewise into two blocks, H and L. For i = 0..3, with byte 0 least significant:
  - H byte 2i is A byte 4+i, and H byte 7−2i is B byte i.
  - L byte 2i is A byte i, and L byte 7−2i is B byte 4+i.
- **Lane encryption.** Each 32-bit half goes through a 32-round Feistel cipher on 16-bit halves. The lanes are H[63:32], H[31:0], L[63:32] and L[31:0], numbered 0 to 3.
  - Each round computes new_left = right ^ ((left rotl 1) & (left rotl 8)) ^ (left rotl 2) ^ k, and new_right = left.
  - The initial left half is x[15:0] and the initial right half is x[31:16]. The result is {right, left}.
- **Key schedule.** The first key words are k0..k3 = key[63:48], key[47:32], key[31:16] and key[15:0].
  - Each further word is k(i+4) = 0xFFFC ^ z(i) ^ k(i) ^ t ^ (t rotr 1), with t = (k(i+3) rotr 3) ^ k(i+1).
  - z(i) is bit 63−i of 0xFA2561CDF44AC398.
  - Round r of lane n uses word 4·(r/4) + ((r+n) mod 4).
  - The digest is {lane0, lane1} ^ {lane2, lane3}.

Top module: `ret_hash_unit`

## Requirements
- R1: The word is a store when insn[31:26] = 31 and insn[10:1] = 1011010010, and a check when insn[31:26] = 31 and insn[10:1] = 1011110010. Any other word accepted while `isa_v31` is high completes with `illegal` set and no memory access.
- R2: The effective address is A + D. D is all ones above bit 8, holds d = {insn[0], insn[25:21]} in bits 8:3, and is zero in bits 2:0, so A − 512 + 8·d.
- R3: When the A register field insn[20:16] is zero, the instruction completes with `illegal` = 1, `trap` = 0 and no memory access, one cycle after acceptance.
- R4: With `isa_v31` low, any accepted word completes with `trap` = 0, `illegal` = 0 and no memory access. This takes priority over R1 and R3.
- R5: The digest follows the interleave, lane cipher and key schedule defined above.
- R6: A store performs exactly one access: a write (`mem_we` = 1) of the digest to the effective address.
- R7: A check performs exactly one read (`mem_we` = 0) at the effective address. `trap` is 1 exactly when the loaded value differs from the digest.
- R8: The key lives in special register 0x1D4 (on `spr_sel`), which resets to zero. A write with `spr_priv` low is ignored. A read with `spr_priv` low returns zero and raises `spr_fault`, and so does a write.
- R9: While `mem_req` is high without `mem_ack`, the request, address and direction hold steady in the next cycle.
- R10: `done` is a one-cycle pulse per accepted instruction. `trap` and `illegal` are zero outside that cycle. `in_ready` stays low from acceptance until `done` has ended.
- R11: A check raises its load request in the cycle after acceptance, overlapping the digest computation. A store raises its write only after the digest is complete, more than 32 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, can accept |
| in_insn | input | 32 | Instruction word |
| in_a | input | 64 | Value of register A |
| in_b | input | 64 | Value of register B |
| isa_v31 | input | 1 | Core implements ISA level 3.1 or later |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Check mismatch, valid with done |
| illegal | output | 1 | Invalid form or unknown word, valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Effective address |
| mem_wdata | output | 64 | Digest for writes |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 64 | Load data, valid with mem_ack |
| spr_sel | input | 10 | Special register number |
| spr_rd | input | 1 | Special register read strobe |
| spr_wr | input | 1 | Special register write strobe |
| spr_wdata | input | 64 | Special register write data |
| spr_priv | input | 1 | Access is privileged |
| spr_rdata | output | 64 | Special register read data |
| spr_fault | output | 1 | Unprivileged access to the key register |

## Verification
The bench sweeps all 64 displacement codes with both variants, so a misplaced or unscaled displacement bit would land the address 8·2^k bytes away. It flips every one of the 64 bits of a correct loaded value; a comparator that ignored a lane or a half would miss some of those traps. Digests are compared against an arithmetic model of the byte interleave, cipher and key schedule under several keys, including zero and a key changed between two instructions, so a swapped lane, a wrong key rotation or a stale key produces a wrong doubleword. It also covers the priority of a too-old ISA level over the invalid form and unknown opcodes, and checks that a check load starts in the first cycle while a store waits for the digest.

// File: rtl/ret_hash_pkg.sv
package ret_hash_pkg;

  localparam logic [5:0]  PRIMARY_OP = 6'd31;
  localparam logic [9:0]  XO_STORE   = 10'b1011010010;
  localparam logic [9:0]  XO_CHECK   = 10'b1011110010;
  localparam logic [63:0] ZSEQ       = 64'hFA25_61CD_F44A_C398;
  localparam logic [15:0] RCONST     = 16'hFFFC;

  typedef enum logic {OP_STORE = 1'b0, OP_CHECK = 1'b1} hop_e;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_STORE, S_FIN} hstate_e;

  function automatic logic [15:0] rotl16(input logic [15:0] v, input int unsigned n);
    logic [31:0] w;
    w = {v, v} << n;
    return w[31:16];
  endfunction

  function automatic logic [15:0] rotr16(input logic [15:0] v, input int unsigned n);
    return rotl16(v, 16 - n);
  endfunction

  // one key-schedule step: a = k(i), b = k(i+1), d = k(i+3)
  function automatic logic [15:0] ks_next(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] d, input logic zb);
    logic [15:0] t;
    t = rotr16(d, 3) ^ b;
    return RCONST ^ {15'd0, zb} ^ a ^ t ^ rotr16(t, 1);
  endfunction

  // byte interleave of the operands into {H, L}
  function automatic logic [127:0] pack_block(input logic [63:0] ra, input logic [63:0] rb);
    logic [63:0] h, l;
    h = '0;
    l = '0;
    for (int i = 0; i < 4; i++) begin
      h[8*(7-2*i) +: 8] = rb[8*i +: 8];
      h[16*i +: 8]      = ra[8*(4+i) +: 8];
      l[8*(7-2*i) +: 8] = rb[8*(4+i) +: 8];
      l[16*i +: 8]      = ra[8*i +: 8];
    end
    return {h, l};
  endfunction

endpackage

// File: rtl/hash_decode.sv
module hash_decode
  import ret_hash_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] a_val,
  output logic            is_store,
  output logic            is_check,
  output logic            ra_zero,
  output logic [XLEN-1:0] ea
);
  localparam int DW = 6;
  localparam int SC = 3;

  logic [DW-1:0]   dfield;
  logic [XLEN-1:0] disp;
  logic            unused_rb;

  assign dfield    = {insn[0], insn[25:21]};
  assign disp      = {{(XLEN-DW-SC){1'b1}}, dfield, {SC{1'b0}}};
  assign is_store  = (insn[31:26] == PRIMARY_OP) && (insn[10:1] == XO_STORE);
  assign is_check  = (insn[31:26] == PRIMARY_OP) && (insn[10:1] == XO_CHECK);
  assign ra_zero   = (insn[20:16] == 5'd0);
  assign ea        = a_val + disp;
  assign unused_rb = ^insn[15:11];
endmodule

// File: rtl/hash_key_reg.sv
module hash_key_reg #(
  parameter int               XLEN    = 64,
  parameter int               SPR_W   = 10,
  parameter logic [SPR_W-1:0] SPR_NUM = 'h1D4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPR_W-1:0] spr_sel,
  input  logic             spr_rd,
  input  logic             spr_wr,
  input  logic [XLEN-1:0]  spr_wdata,
  input  logic             spr_priv,
  output logic [XLEN-1:0]  spr_rdata,
  output logic             spr_fault,
  output logic [XLEN-1:0]  key
);
  logic            hit;
  logic [XLEN-1:0] key_q;

  assign hit       = (spr_sel == SPR_NUM);
  assign spr_fault = hit && (spr_rd || spr_wr) && !spr_priv;
  assign spr_rdata = (hit && spr_rd && spr_priv) ? key_q : '0;
  assign key       = key_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          key_q <= '0;
    else if (hit && spr_wr && spr_priv)  key_q <= spr_wdata;
  end

  AST_KEY_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    !spr_priv |=> $stable(key_q)); // R8
endmodule

// File: rtl/hash_lane.sv
module hash_lane
  import ret_hash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        step,
  input  logic [31:0] x_init,
  input  logic [15:0] ek,
  output logic [31:0] result
);
  logic [15:0] lft, rgt, fmix;

  assign fmix   = (rotl16(lft, 1) & rotl16(lft, 8)) ^ rotl16(lft, 2);
  assign result = {rgt, lft};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lft <= '0;
      rgt <= '0;
    end else if (load) begin
      lft <= x_init[15:0];
      rgt <= x_init[31:16];
    end else if (step) begin
      lft <= rgt ^ fmix ^ ek;
      rgt <= lft;
    end
  end
endmodule

// File: rtl/hash_core.sv
module hash_core
  import ret_hash_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [63:0]  key,
  input  logic [127:0] blk,
  output logic         valid,
  output logic [63:0]  digest
);
  localparam int LANES = 4;
  localparam int RW    = $clog2(ROUNDS);
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  logic [RW-1:0] rnd;
  logic          run_q, valid_q;
  logic [15:0]   grp [LANES];
  logic [15:0]   nxt [LANES];
  logic [31:0]   lane_out [LANES];
  logic [5:0]    zpos;

  assign zpos = 6'd63 - 6'({rnd[RW-1:2], 2'b00});

  always_comb begin
    nxt[0] = ks_next(grp[0], grp[1], grp[3], ZSEQ[zpos]);
    nxt[1] = ks_next(grp[1], grp[2], nxt[0], ZSEQ[zpos - 6'd1]);
    nxt[2] = ks_next(grp[2], grp[3], nxt[1], ZSEQ[zpos - 6'd2]);
    nxt[3] = ks_next(grp[3], nxt[0], nxt[2], ZSEQ[zpos - 6'd3]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      rnd     <= '0;
      for (int j = 0; j < LANES; j++) grp[j] <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      valid_q <= 1'b0;
      rnd     <= '0;
      for (int j = 0; j < LANES; j++) grp[j] <= key[16*(LANES-1-j) +: 16];
    end else if (run_q) begin
      rnd <= rnd + 1'b1;
      if (rnd[1:0] == 2'd3)
        for (int j = 0; j < LANES; j++) grp[j] <= nxt[j];
      if (rnd == LAST) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [1:0] pick;
    assign pick = rnd[1:0] + 2'(L);
    hash_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .step   (run_q),
      .x_init (blk[127-32*L -: 32]),
      .ek     (grp[pick]),
      .result (lane_out[L])
    );
  end

  assign valid  = valid_q;
  assign digest = {lane_out[0], lane_out[1]} ^ {lane_out[2], lane_out[3]};

  AST_CORE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q && !valid); // R5
endmodule

// File: rtl/ret_hash_unit.sv
module ret_hash_unit
  import ret_hash_pkg::*;
#(
  parameter int               ROUNDS  = 32,
  parameter int               SPR_W   = 10,
  parameter logic [SPR_W-1:0] KEY_SPR = 'h1D4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_insn,
  input  logic [63:0]      in_a,
  input  logic [63:0]      in_b,
  input  logic             isa_v31,
  output logic             done,
  output logic             trap,
  output logic             illegal,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  input  logic [SPR_W-1:0] spr_sel,
  input  logic             spr_rd,
  input  logic             spr_wr,
  input  logic [63:0]      spr_wdata,
  input  logic             spr_priv,
  output logic [63:0]      spr_rdata,
  output logic             spr_fault
);
  localparam int XLEN = 64;

  hstate_e         state;
  hop_e            op_q;
  logic [XLEN-1:0] ea_q, ld_val, ea_c, key, digest;
  logic            ld_pend, trap_q, ill_q;
  logic            is_store, is_check, ra_zero, accept, go, core_valid;

  hash_decode #(.XLEN(XLEN)) u_decode (
    .insn     (in_insn),
    .a_val    (in_a),
    .is_store (is_store),
    .is_check (is_check),
    .ra_zero  (ra_zero),
    .ea       (ea_c)
  );

  hash_key_reg #(.XLEN(XLEN), .SPR_W(SPR_W), .SPR_NUM(KEY_SPR)) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .spr_sel   (spr_sel),
    .spr_rd    (spr_rd),
    .spr_wr    (spr_wr),
    .spr_wdata (spr_wdata),
    .spr_priv  (spr_priv),
    .spr_rdata (spr_rdata),
    .spr_fault (spr_fault),
    .key       (key)
  );

  assign accept = in_valid && in_ready;
  assign go     = accept && isa_v31 && (is_store || is_check) && !ra_zero;

  hash_core #(.ROUNDS(ROUNDS)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go),
    .key    (key),
    .blk    (pack_block(in_a, in_b)),
    .valid  (core_valid),
    .digest (digest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_STORE;
      ea_q    <= '0;
      ld_val  <= '0;
      ld_pend <= 1'b0;
      trap_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          trap_q <= 1'b0;
          ill_q  <= 1'b0;
          if (!isa_v31) begin
            state <= S_FIN;
          end else if (!(is_store || is_check) || ra_zero) begin
            ill_q <= 1'b1;
            state <= S_FIN;
          end else begin
            op_q    <= is_check ? OP_CHECK : OP_STORE;
            ea_q    <= ea_c;
            ld_pend <= is_check;
            state   <= S_RUN;
          end
        end
        S_RUN: begin
          if (ld_pend && mem_ack) begin
            ld_val  <= mem_rdata;
            ld_pend <= 1'b0;
          end
          if (core_valid && !ld_pend) begin
            if (op_q == OP_STORE) begin
              state <= S_STORE;
            end else begin
              trap_q <= (ld_val != digest);
              state  <= S_FIN;
            end
          end
        end
        S_STORE: if (mem_ack) state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign done      = (state == S_FIN);
  assign trap      = done && trap_q;
  assign illegal   = done && ill_q;
  assign mem_req   = ((state == S_RUN) && ld_pend) || (state == S_STORE);
  assign mem_we    = (state == S_STORE);
  assign mem_addr  = ea_q;
  assign mem_wdata = mem_we ? digest : '0;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ILLEGAL_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(in_valid && in_ready)); // R3
  AST_LOAD_IS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> op_q == OP_CHECK); // R7
  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && illegal)); // R7
endmodule

// File: tb/ret_hash_unit_bench.sv
`timescale 1ns/1ps
module ret_hash_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, isa_v31 = 1'b1;
  logic [31:0] in_insn = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        done, trap, illegal, mem_req, mem_we, mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [9:0]  spr_sel = '0;
  logic        spr_rd = 1'b0, spr_wr = 1'b0, spr_priv = 1'b0, spr_fault;
  logic [63:0] spr_wdata = '0, spr_rdata;

  always #2.5 clk = ~clk;

  ret_hash_unit u_ret_hash_unit (.*);

  int checks = 0, errors = 0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
  logic [63:0] cur_key = '0;

  bit          r_trap, r_ill, r_we, r_pulse_ok, r_ready_ok;
  int          r_nacc, r_req_cyc;
  logic [63:0] r_addr, r_wdata;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [15:0] brol(input logic [15:0] v, input int n);
    return (v << n) | (v >> (16 - n));
  endfunction

  function automatic logic [31:0] ref_lane(input logic [31:0] x, input logic [63:0] k64, input int lane);
    logic [15:0] k [32];
    logic [15:0] l, r, t, f, ek;
    logic [63:0] zs;
    zs = 64'hFA25_61CD_F44A_C398;
    k[0] = k64[63:48]; k[1] = k64[47:32]; k[2] = k64[31:16]; k[3] = k64[15:0];
    for (int i = 0; i < 28; i++) begin
      t = brol(k[i+3], 13) ^ k[i+1];
      k[i+4] = 16'hFFFC ^ {15'd0, zs[63-i]} ^ k[i] ^ t ^ brol(t, 15);
    end
    l = x[15:0];
    r = x[31:16];
    for (int i = 0; i < 32; i++) begin
      ek = k[4*(i/4) + ((i%4 + lane) % 4)];
      f  = (brol(l, 1) & brol(l, 8)) ^ brol(l, 2);
      t  = l;
      l  = r ^ f ^ ek;
      r  = t;
    end
    return {r, l};
  endfunction

  function automatic logic [63:0] ref_digest(input logic [63:0] ra, input logic [63:0] rb, input logic [63:0] k64);
    logic [63:0] h, l;
    for (int i = 0; i < 4; i++) begin
      h[8*(7-2*i) +: 8] = rb[8*i +: 8];
      h[16*i +: 8]      = ra[8*(4+i) +: 8];
      l[8*(7-2*i) +: 8] = rb[8*(4+i) +: 8];
      l[16*i +: 8]      = ra[8*i +: 8];
    end
    return {ref_lane(h[63:32], k64, 0), ref_lane(h[31:0], k64, 1)}
         ^ {ref_lane(l[63:32], k64, 2), ref_lane(l[31:0], k64, 3)};
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [9:0] xo,
                                     input logic [4:0] ra, input logic [5:0] d);
    return {po, d[4:0], ra, 5'd4, xo, d[5]};
  endfunction

  function automatic logic [63:0] exp_ea(input logic [63:0] a, input int d);
    return a - 64'd512 + 64'(8 * d);
  endfunction

  task automatic spr_write(input logic [63:0] v, input bit priv);
    @(negedge clk);
    spr_sel = 10'h1D4; spr_wdata = v; spr_priv = priv; spr_wr = 1'b1;
    @(negedge clk);
    spr_wr = 1'b0;
  endtask

  task automatic spr_read(input bit priv, output logic [63:0] v, output bit f);
    @(negedge clk);
    spr_sel = 10'h1D4; spr_priv = priv; spr_rd = 1'b1;
    #1;
    v = spr_rdata; f = spr_fault;
    spr_rd = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] insn, input logic [63:0] a, input logic [63:0] b,
                        input bit isa, input logic [63:0] ldv, input int lat);
    int cyc, w, guard;
    r_trap = 0; r_ill = 0; r_we = 0; r_nacc = 0; r_req_cyc = -1;
    r_addr = '0; r_wdata = '0; r_pulse_ok = 1; r_ready_ok = 1;
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_a = a; in_b = b; isa_v31 = isa;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1; w = 0; guard = 0;
    while (!done && guard < 2000) begin
      if (in_ready) r_ready_ok = 0;
      if (trap || illegal) r_pulse_ok = 0;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (r_req_cyc < 0) r_req_cyc = cyc;
        if (w >= lat) begin
          mem_ack = 1'b1; mem_rdata = ldv;
          r_addr = mem_addr; r_we = mem_we; r_wdata = mem_wdata;
          r_nacc++; w = 0;
        end else w++;
      end
      @(negedge clk);
      cyc++; guard++;
    end
    mem_ack = 1'b0;
    r_trap = trap; r_ill = illegal;
    @(negedge clk);
    if (done || trap || illegal || mem_req) r_pulse_ok = 0;
    if (!in_ready) r_ready_ok = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] v, a, b, e, k2;
    bit f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 1);
    chk(!done && !trap && !illegal, "R10 idle outputs after reset", 64'(done), 0);
    chk(mem_req == 1'b0, "R6 no request after reset", 64'(mem_req), 0);
    spr_read(1, v, f);
    chk(v == 0 && !f, "R8 key resets to zero", v, 0);

    // zero key digest
    a = rnd64(); b = rnd64();
    run_op(mk(6'd31, 10'b1011010010, 5'd1, 6'd5), a, b, 1, 0, 0);
    chk(r_wdata == ref_digest(a, b, 64'd0), "R5 digest with zero key", r_wdata, ref_digest(a, b, 64'd0));

    // privilege rules on the key register
    spr_write(64'hDEAD_BEEF_0BAD_F00D, 0);
    spr_read(1, v, f);
    chk(v == 0, "R8 unprivileged write ignored", v, 0);
    spr_read(0, v, f);
    chk(v == 0 && f, "R8 unprivileged read faults", {v[62:0], f}, 1);
    cur_key = 64'h0123_4567_89AB_CDEF;
    spr_write(cur_key, 1);
    spr_read(1, v, f);
    chk(v == cur_key && !f, "R8 privileged write/read", v, cur_key);

    // store sweep over every displacement code
    for (int d = 0; d < 64; d++) begin
      a = rnd64(); b = rnd64();
      e = ref_digest(a, b, cur_key);
      run_op(mk(6'd31, 10'b1011010010, 5'(1 + d % 31), 6'(d)), a, b, 1, 0, d % 4);
      chk(r_addr == exp_ea(a, d), "R2 store address", r_addr, exp_ea(a, d));
      chk(r_wdata == e, "R5 R6 store digest", r_wdata, e);
      chk(r_we && r_nacc == 1, "R6 single write", 64'(r_nacc), 1);
      chk(!r_trap && !r_ill, "R6 store flags", {62'd0, r_trap, r_ill}, 0);
      chk(r_req_cyc > 32, "R11 write waits for digest", 64'(r_req_cyc), 33);
      chk(r_pulse_ok && r_ready_ok, "R10 pulse and ready", {62'd0, r_pulse_ok, r_ready_ok}, 3);
    end

    // check variant: every single-bit mismatch, plus matches
    for (int bit_i = 0; bit_i < 72; bit_i++) begin
      a = rnd64(); b = rnd64();
      e = ref_digest(a, b, cur_key);
      v = (bit_i < 64) ? (e ^ (64'd1 << bit_i)) : e;
      run_op(mk(6'd31, 10'b1011110010, 5'(1 + bit_i % 31), 6'(bit_i % 64)), a, b, 1, v, bit_i % 3);
      chk(r_trap == (bit_i < 64), "R7 trap on mismatch only", 64'(r_trap), 64'(bit_i < 64));
      chk(!r_we && r_nacc == 1 && !r_ill, "R7 single read", 64'(r_nacc), 1);
      chk(r_addr == exp_ea(a, bit_i % 64), "R2 check address", r_addr, exp_ea(a, bit_i % 64));
      chk(r_req_cyc == 1, "R11 load starts at once", 64'(r_req_cyc), 1);
      chk(r_pulse_ok && r_ready_ok, "R10 pulse and ready", {62'd0, r_pulse_ok, r_ready_ok}, 3);
    end

    // key change takes effect; old digest now traps
    a = rnd64(); b = rnd64();
    e = ref_digest(a, b, cur_key);
    k2 = 64'hF0E1_D2C3_B4A5_9687;
    spr_write(k2, 1);
    run_op(mk(6'd31, 10'b1011010010, 5'd7, 6'd63), a, b, 1, 0, 1);
    chk(r_wdata == ref_digest(a, b, k2), "R8 R5 new key used", r_wdata, ref_digest(a, b, k2));
    run_op(mk(6'd31, 10'b1011110010, 5'd7, 6'd63), a, b, 1, e, 2);
    chk(r_trap == 1'b1, "R8 old-key digest traps", 64'(r_trap), 1);

    // invalid form
    run_op(mk(6'd31, 10'b1011010010, 5'd0, 6'd9), rnd64(), rnd64(), 1, 0, 0);
    chk(r_ill && !r_trap && r_nacc == 0, "R3 store RA=0 illegal", {r_ill, r_trap, 62'(r_nacc)}, 64'h8000_0000_0000_0000);
    run_op(mk(6'd31, 10'b1011110010, 5'd0, 6'd9), rnd64(), rnd64(), 1, 0, 0);
    chk(r_ill && !r_trap && r_nacc == 0, "R3 check RA=0 illegal", {r_ill, r_trap, 62'(r_nacc)}, 64'h8000_0000_0000_0000);
    chk(r_pulse_ok && r_ready_ok, "R10 pulse on illegal", {62'd0, r_pulse_ok, r_ready_ok}, 3);

    // unknown words
    run_op(mk(6'd30, 10'b1011010010, 5'd3, 6'd1), rnd64(), rnd64(), 1, 0, 0);
    chk(r_ill && r_nacc == 0, "R1 wrong primary opcode", {r_ill, 63'(r_nacc)}, 64'h8000_0000_0000_0000);
    run_op(mk(6'd31, 10'b1011010011, 5'd3, 6'd1), rnd64(), rnd64(), 1, 0, 0);
    chk(r_ill && r_nacc == 0, "R1 wrong extended opcode", {r_ill, 63'(r_nacc)}, 64'h8000_0000_0000_0000);

    // ISA level too old
    run_op(mk(6'd31, 10'b1011010010, 5'd3, 6'd2), rnd64(), rnd64(), 0, 0, 0);
    chk(!r_ill && !r_trap && r_nacc == 0, "R4 store is no-op", {r_ill, r_trap, 62'(r_nacc)}, 0);
    run_op(mk(6'd31, 10'b1011110010, 5'd3, 6'd2), rnd64(), rnd64(), 0, 64'hFFFF, 0);
    chk(!r_ill && !r_trap && r_nacc == 0, "R4 check is no-op", {r_ill, r_trap, 62'(r_nacc)}, 0);
    run_op(mk(6'd31, 10'b1011010010, 5'd0, 6'd2), rnd64(), rnd64(), 0, 0, 0);
    chk(!r_ill && r_nacc == 0, "R4 priority over RA=0", {r_ill, 63'(r_nacc)}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule